// File: doc/BRIEF.md
# Crosspoint Configuration Register Interface

This block is the digital configuration front end of a large crosspoint switch with 68 inputs and 68 outputs. A controller reaches it over a parallel bus: a 7-bit channel address, a 7-bit data path, a read/write select, a write strobe, a bank-type select, a routing-bank select and a chip select. Behind the bus sit three banks of 68 seven-bit registers. One bank holds per-channel controls: input equalization, output amplitude, AC-termination enable and channel enable. Two routing banks hold, per output, the index of the input it carries. Every register can be read back.

The routing banks are double buffered. One bank is live and drives the matrix. The other can be programmed while traffic flows, and an explicit update pulse switches it in. A simple digital select per output reproduces the routing end to end, so the configuration can be checked without the analog cells. The block only emits control codes for the equalizers, drivers and terminations. Inside the chip, the data bus is split into an input, an output and an output enable for the pad.

Top module: `xp_cfg_if`

## Requirements
- R1: After reset every control register reads 0x40, meaning the channel is enabled, equalization is 0, amplitude is 0 and DC coupling is selected. Routing register n in both banks reads n. Bank 0 is live.
- R2: A write needs cs=1, rw=0 and a rising edge of wstb, sampled on the clock. It stores data_i into the addressed register of the selected bank: the control bank when cntl=1, otherwise the routing bank given by rbank. Reading the register back then returns that value.
- R3: A read with cs=1 and rw=1 places the addressed register of the selected bank on data_o in the same cycle. Both routing banks are readable whichever bank is live.
- R4: Channel addresses 68 to 127 are ignored on write and read back as 0. Writes to them do not alias to any channel in range.
- R5: data_oe is 1 exactly when cs=1 and rw=1. Otherwise data_oe is 0 and data_o is 0.
- R6: Holding wstb high, strobing with cs=0, or strobing with rw=1 changes no register.
- R7: Each control register decodes to its channel's outputs. Bits 2:0 give eq_o. Bits 4:3 give amp_o, with code 3 saturating to level 2. Bit 5 gives ac_term_o. Bit 6 gives ch_en_o.
- R8: lane_out[n] equals lane_in[s], where s is routing register n of the live bank, when ch_en_o[n]=1 and s<68. Otherwise lane_out[n] is 0.
- R9: Writes to the idle routing bank leave lane_out unchanged. A pulse on upd makes rbank the live bank from the next cycle.
- R10: A write strobe and an update pulse in the same cycle both take effect. The newly live bank, including the value just written, drives lane_out from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| rw | input | 1 | 1 = read, 0 = write |
| wstb | input | 1 | Write strobe, acts on its rising edge |
| cntl | input | 1 | 1 = control bank, 0 = routing bank |
| rbank | input | 1 | Routing bank for access and for update |
| upd | input | 1 | Makes rbank the live routing bank |
| ch | input | 7 | Channel address |
| data_i | input | 7 | Write data |
| data_o | output | 7 | Read data |
| data_oe | output | 1 | Pad output enable for data_o |
| lane_in | input | 68 | Input lanes |
| lane_out | output | 68 | Routed output lanes |
| eq_o | output | 204 | 3-bit equalization code per channel |
| amp_o | output | 136 | 2-bit amplitude level per channel |
| ac_term_o | output | 68 | AC termination enable per channel |
| ch_en_o | output | 68 | Channel power enable per channel |

## Verification
A write strobe and a bank update can land on the same clock edge. The block must then store the word and switch the live bank together, and the word just written must reach the matrix at once. The bench provokes this by holding upd high in the very cycle of a strobe rising edge. After that edge it compares the affected lane with the input that the new word selects. It also checks that a neighbouring lane follows the newly live bank.

// File: rtl/xp_cfg_pkg.sv
package xp_cfg_pkg;
    localparam int AW = 7;
    localparam int DW = 7;

    typedef struct packed {
        logic       en;
        logic       ac;
        logic [1:0] amp;
        logic [2:0] eq;
    } ctrl_t;

    localparam logic [DW-1:0] CTRL_RST = 7'h40;

    function automatic logic [1:0] amp_level(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction
endpackage

// File: rtl/xp_regfile.sv
module xp_regfile
    import xp_cfg_pkg::*;
#(
    parameter int NCH   = 68,
    parameter bit IDENT = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [NCH-1:0][DW-1:0]   q
);
    for (genvar i = 0; i < NCH; i++) begin : g_reg
        localparam logic [DW-1:0] RV = IDENT ? DW'(i) : CTRL_RST;
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= RV;
            else if (we && addr == AW'(i))
                q[i] <= wdata;
        end
    end
endmodule

// File: rtl/xp_matrix.sv
module xp_matrix
    import xp_cfg_pkg::*;
#(
    parameter int NCH = 68
) (
    input  logic [NCH-1:0][DW-1:0] route,
    input  logic [NCH-1:0]         en,
    input  logic [NCH-1:0]         lane_in,
    output logic [NCH-1:0]         lane_out
);
    localparam logic [DW-1:0] LIM = DW'(NCH);
    for (genvar n = 0; n < NCH; n++) begin : g_out
        always_comb begin
            lane_out[n] = 1'b0;
            if (en[n] && route[n] < LIM)
                lane_out[n] = lane_in[route[n]];
        end
    end
endmodule

// File: rtl/xp_cfg_if.sv
module xp_cfg_if
    import xp_cfg_pkg::*;
#(
    parameter int NCH = 68
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rw,
    input  logic              wstb,
    input  logic              cntl,
    input  logic              rbank,
    input  logic              upd,
    input  logic [AW-1:0]     ch,
    input  logic [DW-1:0]     data_i,
    output logic [DW-1:0]     data_o,
    output logic              data_oe,
    input  logic [NCH-1:0]    lane_in,
    output logic [NCH-1:0]    lane_out,
    output logic [NCH*3-1:0]  eq_o,
    output logic [NCH*2-1:0]  amp_o,
    output logic [NCH-1:0]    ac_term_o,
    output logic [NCH-1:0]    ch_en_o
);
    localparam logic [AW-1:0] CH_LIM = AW'(NCH);

    logic                   wstb_q;
    logic                   act_bank;
    logic                   wr_fire;
    logic                   in_range;
    logic [NCH-1:0][DW-1:0] ctrl_q, rt0_q, rt1_q, live_rt, rd_bank;

    assign in_range = (ch < CH_LIM);
    assign wr_fire  = cs && !rw && wstb && !wstb_q && in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            wstb_q   <= 1'b0;
            act_bank <= 1'b0;
        end else begin
            wstb_q <= wstb;
            if (upd)
                act_bank <= rbank;
        end
    end

    xp_regfile #(.NCH(NCH), .IDENT(1'b0)) u_ctrl (
        .clk(clk), .rst(rst), .we(wr_fire && cntl),
        .addr(ch), .wdata(data_i), .q(ctrl_q));
    xp_regfile #(.NCH(NCH), .IDENT(1'b1)) u_rt0 (
        .clk(clk), .rst(rst), .we(wr_fire && !cntl && !rbank),
        .addr(ch), .wdata(data_i), .q(rt0_q));
    xp_regfile #(.NCH(NCH), .IDENT(1'b1)) u_rt1 (
        .clk(clk), .rst(rst), .we(wr_fire && !cntl && rbank),
        .addr(ch), .wdata(data_i), .q(rt1_q));

    assign rd_bank = cntl ? ctrl_q : (rbank ? rt1_q : rt0_q);
    assign data_oe = cs && rw;
    always_comb begin
        data_o = '0;
        if (data_oe && in_range)
            data_o = rd_bank[ch];
    end

    for (genvar n = 0; n < NCH; n++) begin : g_dec
        ctrl_t c;
        assign c                  = ctrl_t'(ctrl_q[n]);
        assign eq_o[n*3 +: 3]     = c.eq;
        assign amp_o[n*2 +: 2]    = amp_level(c.amp);
        assign ac_term_o[n]       = c.ac;
        assign ch_en_o[n]         = c.en;
    end

    assign live_rt = act_bank ? rt1_q : rt0_q;

    xp_matrix #(.NCH(NCH)) u_mx (
        .route(live_rt), .en(ch_en_o), .lane_in(lane_in), .lane_out(lane_out));
endmodule

// File: rtl/xp_cfg_chk.sv
module xp_cfg_chk
    import xp_cfg_pkg::*;
#(
    parameter int NCH = 68
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cs,
    input logic                   rw,
    input logic                   wstb,
    input logic                   rbank,
    input logic                   upd,
    input logic [AW-1:0]          ch,
    input logic [DW-1:0]          data_o,
    input logic                   data_oe,
    input logic                   act_bank,
    input logic [NCH-1:0][DW-1:0] ctrl_q,
    input logic [NCH-1:0][DW-1:0] rt0_q,
    input logic [NCH-1:0][DW-1:0] rt1_q,
    input logic [NCH-1:0]         lane_out
);
    logic stb_d;
    always_ff @(posedge clk) begin
        if (rst) stb_d <= 1'b0;
        else     stb_d <= wstb;
    end

    logic wr_ok;
    assign wr_ok = cs && !rw && wstb && !stb_d && (ch < AW'(NCH));

    a_r6_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> ($stable(ctrl_q) && $stable(rt0_q) && $stable(rt1_q)));

    a_r5_oe_off_without_cs: assert property (@(posedge clk) disable iff (rst)
        !cs |-> (!data_oe && data_o == '0));

    a_r5_oe_off_on_write: assert property (@(posedge clk) disable iff (rst)
        !rw |-> !data_oe);

    a_r4_oor_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (ch >= AW'(NCH)) |-> data_o == '0);

    a_r9_bank_held: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(act_bank));

    a_r9_bank_taken: assert property (@(posedge clk) disable iff (rst)
        upd |=> act_bank == $past(rbank));

    for (genvar n = 0; n < NCH; n++) begin : g_en
        a_r8_disabled_low: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q[n][6] |-> !lane_out[n]);
    end
endmodule

bind xp_cfg_if xp_cfg_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .rw(rw), .wstb(wstb), .rbank(rbank),
    .upd(upd), .ch(ch), .data_o(data_o), .data_oe(data_oe),
    .act_bank(act_bank), .ctrl_q(ctrl_q), .rt0_q(rt0_q), .rt1_q(rt1_q),
    .lane_out(lane_out));

// File: tb/xp_cfg_if_tb.sv
module xp_cfg_if_tb;
    localparam int NCH = 68;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 0, rw = 0, wstb = 0, cntl = 0, rbank = 0, upd = 0;
    logic [6:0] ch = 0, data_i = 0;
    logic [6:0] data_o;
    logic data_oe;
    logic [NCH-1:0] lane_in = '0, lane_out, ac_term_o, ch_en_o;
    logic [NCH*3-1:0] eq_o;
    logic [NCH*2-1:0] amp_o;

    int checks = 0, errors = 0;
    logic [6:0] m_ctrl [NCH];
    logic [6:0] m_rt   [2][NCH];
    logic       m_act;

    always #4 clk = ~clk;

    xp_cfg_if #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .cs(cs), .rw(rw), .wstb(wstb), .cntl(cntl),
        .rbank(rbank), .upd(upd), .ch(ch), .data_i(data_i), .data_o(data_o),
        .data_oe(data_oe), .lane_in(lane_in), .lane_out(lane_out), .eq_o(eq_o),
        .amp_o(amp_o), .ac_term_o(ac_term_o), .ch_en_o(ch_en_o));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic b, input int a, input int d, input logic u = 1'b0);
        @(negedge clk);
        cs = 1; rw = 0; cntl = c; rbank = b; ch = 7'(a); data_i = 7'(d); wstb = 0;
        @(negedge clk);
        wstb = 1; upd = u;
        @(negedge clk);
        wstb = 0; upd = 0; cs = 0;
    endtask

    task automatic rd(input logic c, input logic b, input int a, output int v);
        @(negedge clk);
        cs = 1; rw = 1; cntl = c; rbank = b; ch = 7'(a);
        #1 v = int'(data_o);
        @(negedge clk);
        cs = 0; rw = 0;
    endtask

    function automatic logic exp_lane(int n);
        int s;
        s = int'(m_rt[m_act][n]);
        if (!m_ctrl[n][6] || s >= NCH) return 1'b0;
        return lane_in[s];
    endfunction

    task automatic check_lanes(input string req);
        for (int p = 0; p < 3; p++) begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++) lane_in[i] = (((i * (p + 3) + p) % 5) < 2);
            #1;
            for (int n = 0; n < NCH; n++) chk(req, lane_out[n], exp_lane(n));
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        for (int n = 0; n < NCH; n++) begin
            m_ctrl[n] = 7'h40; m_rt[0][n] = 7'(n); m_rt[1][n] = 7'(n);
        end
        m_act = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset values
        chk("R1 oe", data_oe, 0);
        for (int n = 0; n < NCH; n++) begin
            rd(1, 0, n, v); chk("R1 ctrl", v, 'h40);
            rd(0, 0, n, v); chk("R1 rt0", v, n);
            rd(0, 1, n, v); chk("R1 rt1", v, n);
        end
        check_lanes("R1 R8 identity");

        // R2 control writes, R7 decode, R8 enable gating
        for (int n = 0; n < NCH; n++) begin
            m_ctrl[n] = 7'((n * 29 + 11) % 128);
            wr(1, 0, n, m_ctrl[n]);
        end
        for (int n = 0; n < NCH; n++) begin
            int a;
            rd(1, 0, n, v); chk("R2 ctrl readback", v, m_ctrl[n]);
            a = (m_ctrl[n] >> 3) & 3;
            chk("R7 eq",  eq_o[n*3 +: 3], m_ctrl[n] & 7);
            chk("R7 amp", amp_o[n*2 +: 2], (a == 3) ? 2 : a);
            chk("R7 ac",  ac_term_o[n], (m_ctrl[n] >> 5) & 1);
            chk("R7 en",  ch_en_o[n], (m_ctrl[n] >> 6) & 1);
        end
        check_lanes("R8 gated");

        // R9 stage idle bank 1, R3 readback of both banks
        for (int n = 0; n < NCH; n++) begin
            m_rt[1][n] = (n == 7) ? 7'd100 : 7'((n * 5 + 3) % NCH);
            wr(0, 1, n, m_rt[1][n]);
        end
        for (int n = 0; n < NCH; n++) begin
            rd(0, 1, n, v); chk("R3 rt1 readback", v, m_rt[1][n]);
            rd(0, 0, n, v); chk("R3 rt0 readback", v, n);
        end
        check_lanes("R9 staged no effect");
        @(negedge clk); rbank = 1; upd = 1;
        @(negedge clk); upd = 0; m_act = 1;
        check_lanes("R9 R8 after update");

        // R4 out-of-range addresses
        wr(1, 0, 100, 'h15);
        wr(0, 0, 68, 'h05);
        rd(1, 0, 100, v); chk("R4 oor read", v, 0);
        rd(1, 0, 127, v); chk("R4 oor read", v, 0);
        rd(1, 0, 32, v);  chk("R4 no alias", v, m_ctrl[32]);
        rd(0, 0, 0, v);   chk("R4 no alias", v, 0);

        // R5 bus direction
        @(negedge clk); cs = 0; rw = 1; #1 chk("R5 oe cs=0", data_oe, 0); chk("R5 data cs=0", data_o, 0);
        @(negedge clk); cs = 1; rw = 0; #1 chk("R5 oe rw=0", data_oe, 0);
        @(negedge clk); cs = 1; rw = 1; #1 chk("R5 oe read", data_oe, 1);
        @(negedge clk); cs = 0; rw = 0;

        // R6 ignored strobes
        @(negedge clk); cs = 1; rw = 0; cntl = 1; ch = 3; data_i = 1; wstb = 1;
        @(negedge clk); data_i = 2;
        @(negedge clk); data_i = 3;
        @(negedge clk); wstb = 0;
        rd(1, 0, 3, v); chk("R6 held strobe", v, 1);
        m_ctrl[3] = 1;
        @(negedge clk); cs = 0; rw = 0; cntl = 1; ch = 3; data_i = 9;
        @(negedge clk); wstb = 1;
        @(negedge clk); wstb = 0;
        rd(1, 0, 3, v); chk("R6 cs low", v, 1);
        @(negedge clk); cs = 1; rw = 1; cntl = 1; ch = 3; data_i = 9;
        @(negedge clk); wstb = 1;
        @(negedge clk); wstb = 0; cs = 0;
        rd(1, 0, 3, v); chk("R6 rw high", v, 1);

        // R10 write and update in the same cycle
        wr(1, 0, 5, 'h40); m_ctrl[5] = 7'h40;
        wr(1, 0, 6, 'h40); m_ctrl[6] = 7'h40;
        @(negedge clk); lane_in = '0; lane_in[9] = 1'b1; lane_in[6] = 1'b1;
        wr(0, 0, 5, 9, 1'b1);
        m_rt[0][5] = 9; m_act = 0;
        #1;
        chk("R10 lane5", lane_out[5], 1);
        chk("R10 lane6", lane_out[6], 1);
        rd(0, 0, 5, v); chk("R10 readback", v, 9);
        check_lanes("R10 bank0 live");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule